// File: doc/BRIEF.md
# Single-Precision Sign-Injection Unit for a 64-bit Float Path

This unit sits in a 64-bit floating-point register datapath and performs the single-precision sign-injection family. It can copy the sign of a second operand onto a first, copy the inverted sign, or xor the two signs. A 32-bit value held in a 64-bit register is only valid when it is NaN-boxed, which means its upper half is all ones. Each operand is tested for this first. Any operand that fails the test is replaced by the boxed canonical single-precision NaN, and only then is the sign bit worked on. Because of this, every result leaves the unit correctly boxed.

The move, negate and absolute-value idioms are the same operations with both operands taken from one register. They need no special path, because the general formulas already give the right answer when both operands are equal. No exponent or mantissa bit is ever altered, and no exception is raised, even for a signalling NaN.

Requests arrive on a valid/ready stream and results leave on one. The result is registered, so with the consumer ready it appears one clock after acceptance. While a result is valid and `res_ready` is low, the result holds steady and `req_ready` stays low. A new request is accepted whenever the output register is empty or is being drained in the same cycle. Each result carries a flag marking the float state dirty and a flag marking a reserved operation code.

Top module: `fsgn_inject`

## Requirements
- R1: An operand whose bits 63..32 are all ones is used unchanged.
- R2: An operand with any zero in bits 63..32 is replaced by 0xFFFF_FFFF_7FC0_0000 before the sign operation.
- R3: With `req_op` = 2'b00 (copy sign), the result is bits 63..31 of checked B joined with bits 30..0 of checked A.
- R4: With `req_op` = 2'b01 (inverted sign), the result is checked A with bit 31 replaced by the inverse of bit 31 of checked B.
- R5: With `req_op` = 2'b10 (xor sign), the result is checked A with bit 31 replaced by the xor of bit 31 of both checked operands.
- R6: With `req_op` = 2'b11 (reserved), the result is 0xFFFF_FFFF_7FC0_0000 and `res_illegal` is 1. For every other code `res_illegal` is 0.
- R7: Every valid result has bits 63..32 all ones.
- R8: Every valid result has `res_dirty` set. Synchronous active-high reset clears `res_valid` and `res_dirty`.
- R9: When the output is free, a request accepted at a clock edge appears on the outputs at the next edge. An idle input cycle with `res_ready` high leaves `res_valid` low.
- R10: While `res_valid` is 1 and `res_ready` is 0, the result fields stay stable and `req_ready` is 0.
- R11: When A equals B (move, negate and absolute value), the result equals the general formula of R3 to R5, including the replacement of an unboxed input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_a | input | 64 | Operand supplying magnitude |
| req_b | input | 64 | Operand supplying sign |
| req_op | input | 2 | 00 copy, 01 inverted, 10 xor, 11 reserved |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 64 | Boxed result |
| res_dirty | output | 1 | Float state modified by this result |
| res_illegal | output | 1 | Result came from the reserved code |

## Verification
The assertions assume that reset is applied at the first clock, so they are disabled under reset. They also assume the consumer follows the stream rules and the producer never retracts a request. The bench changes inputs only away from the clock edge and keeps requests steady while `req_ready` is low. The sweep crosses every operation code with every pair from a set of operands. That set covers boxed positive and negative values, a boxed signalling NaN, the canonical NaN itself and several nearly boxed or unboxed words. Equal pairs are included in the sweep, and a stall phase holds `res_ready` low across several cycles.

// File: rtl/fsgn_pkg.sv
package fsgn_pkg;
  localparam int FLEN  = 64;
  localparam int SLEN  = 32;
  localparam int EXP_W = 8;

  typedef enum logic [1:0] {
    SGN_COPY = 2'b00,
    SGN_INV  = 2'b01,
    SGN_XOR  = 2'b10,
    SGN_RSVD = 2'b11
  } sgn_op_e;
endpackage

// File: rtl/fsgn_box_check.sv
module fsgn_box_check #(
  parameter int FLEN  = 64,
  parameter int SLEN  = 32,
  parameter int EXP_W = 8
) (
  input  logic [FLEN-1:0] raw,
  output logic [FLEN-1:0] checked,
  output logic            boxed
);
  localparam int PAD_W  = FLEN - SLEN;
  localparam int FRAC_W = SLEN - EXP_W - 1;
  localparam logic [FLEN-1:0] CANON =
    {{PAD_W{1'b1}}, 1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  always_comb begin
    boxed   = &raw[FLEN-1:SLEN];
    checked = boxed ? raw : CANON;
  end
endmodule

// File: rtl/fsgn_core.sv
module fsgn_core
  import fsgn_pkg::*;
#(
  parameter int FLEN  = 64,
  parameter int SLEN  = 32,
  parameter int EXP_W = 8
) (
  input  logic [FLEN-1:0] a,
  input  logic [FLEN-1:0] b,
  input  sgn_op_e         op,
  output logic [FLEN-1:0] res,
  output logic            illegal
);
  localparam int SB     = SLEN - 1;
  localparam int PAD_W  = FLEN - SLEN;
  localparam int FRAC_W = SLEN - EXP_W - 1;
  localparam logic [FLEN-1:0] CANON =
    {{PAD_W{1'b1}}, 1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  always_comb begin
    illegal = 1'b0;
    res     = a;
    unique case (op)
      SGN_COPY: res = {b[FLEN-1:SB], a[SB-1:0]};
      SGN_INV:  res[SB] = ~b[SB];
      SGN_XOR:  res[SB] = a[SB] ^ b[SB];
      default: begin
        res     = CANON;
        illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fsgn_inject.sv
module fsgn_inject
  import fsgn_pkg::*;
#(
  parameter int FL = fsgn_pkg::FLEN,
  parameter int SL = fsgn_pkg::SLEN,
  parameter int EW = fsgn_pkg::EXP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [FL-1:0] req_a,
  input  logic [FL-1:0] req_b,
  input  logic [1:0]    req_op,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [FL-1:0] res_data,
  output logic          res_dirty,
  output logic          res_illegal
);
  localparam int NOPS  = 2;
  localparam int PAD_W = FL - SL;

  logic [FL-1:0] raw_v [NOPS];
  logic [FL-1:0] chk_v [NOPS];
  logic [NOPS-1:0] boxed_v;
  logic [FL-1:0] core_res;
  logic          core_ill;
  logic          take;

  assign raw_v[0] = req_a;
  assign raw_v[1] = req_b;

  for (genvar i = 0; i < NOPS; i++) begin : g_box
    fsgn_box_check #(.FLEN(FL), .SLEN(SL), .EXP_W(EW)) box_i (
      .raw(raw_v[i]), .checked(chk_v[i]), .boxed(boxed_v[i])
    );
  end

  fsgn_core #(.FLEN(FL), .SLEN(SL), .EXP_W(EW)) core_i (
    .a(chk_v[0]), .b(chk_v[1]), .op(sgn_op_e'(req_op)),
    .res(core_res), .illegal(core_ill)
  );

  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_dirty <= 1'b0;
    end else if (req_ready) begin
      res_valid <= req_valid;
      res_dirty <= req_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      res_data    <= core_res;
      res_illegal <= core_ill;
    end
  end

  a_r7_boxed_out: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_data[FL-1:SL] == {PAD_W{1'b1}}));
  a_r8_dirty_with_valid: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_dirty);
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> res_valid);
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_illegal)));
  a_r10_no_accept: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |-> !req_ready);
  a_r6_illegal_canon: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_illegal) |-> (res_data[SL-1:0] == 32'h7FC0_0000));
endmodule

// File: tb/fsgn_inject_tb_top.sv
module fsgn_inject_tb_top;
  localparam logic [63:0] CANON = 64'hFFFF_FFFF_7FC0_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, res_valid, res_ready;
  logic [63:0] req_a, req_b, res_data;
  logic [1:0]  req_op;
  logic        res_dirty, res_illegal;
  int checks = 0;
  int errors = 0;
  logic [63:0] pats [8];

  always #2.5 clk = ~clk;

  fsgn_inject dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_a(req_a), .req_b(req_b), .req_op(req_op), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_dirty(res_dirty),
    .res_illegal(res_illegal)
  );

  function automatic logic [63:0] boxchk(input logic [63:0] x);
    return (x[63:32] == 32'hFFFF_FFFF) ? x : CANON;
  endfunction

  function automatic logic [63:0] model(input logic [63:0] a0, input logic [63:0] b0,
                                        input logic [1:0] op);
    logic [63:0] a, b, r;
    a = boxchk(a0);
    b = boxchk(b0);
    r = a;
    case (op)
      2'b00: r = {b[63:31], a[30:0]};
      2'b01: r[31] = ~b[31];
      2'b10: r[31] = a[31] ^ b[31];
      default: r = CANON;
    endcase
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic one(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op);
    logic [63:0] e;
    string tag;
    e = model(a, b, op);
    tag = (a == b) ? "R11" : (op == 2'b00) ? "R3" : (op == 2'b01) ? "R4" :
          (op == 2'b10) ? "R5" : "R6";
    @(negedge clk);
    req_valid = 1'b1; req_a = a; req_b = b; req_op = op;
    @(negedge clk);
    req_valid = 1'b0;
    check(res_valid === 1'b1, "R9 valid", {63'd0, res_valid}, 64'd1);
    check(res_data === e, tag, res_data, e);
    check(res_dirty === 1'b1, "R8 dirty", {63'd0, res_dirty}, 64'd1);
    check(res_illegal === (op == 2'b11), "R6 flag", {63'd0, res_illegal},
          {63'd0, op == 2'b11});
    check(res_data[63:32] === 32'hFFFF_FFFF, "R7 boxed", res_data, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    pats[0] = 64'hFFFF_FFFF_3F80_0000;
    pats[1] = 64'hFFFF_FFFF_C120_0000;
    pats[2] = 64'hFFFF_FFFF_7F80_0001;
    pats[3] = CANON;
    pats[4] = 64'h0000_0000_BF80_0000;
    pats[5] = 64'hFFFF_FFFE_4040_0000;
    pats[6] = 64'h7FFF_FFFF_FFFF_FFFF;
    pats[7] = 64'hFFFF_FFFF_8000_0000;
    rst = 1'b1; req_valid = 1'b0; res_ready = 1'b1;
    req_a = '0; req_b = '0; req_op = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(res_valid === 1'b0, "R8 reset valid", {63'd0, res_valid}, 64'd0);
    check(res_dirty === 1'b0, "R8 reset dirty", {63'd0, res_dirty}, 64'd0);
    // R1 R2 via the sweep: boxed values pass, unboxed turn into canonical NaN
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          one(pats[i], pats[j], 2'(op));
    // R1: boxed signalling NaN through a move keeps all bits
    one(pats[2], pats[2], 2'b00);
    check(res_data === pats[2], "R1 move snan", res_data, pats[2]);
    // R2: unboxed move yields canonical NaN
    one(pats[4], pats[4], 2'b00);
    check(res_data === CANON, "R2 replace", res_data, CANON);
    // R9: idle cycle clears valid
    @(negedge clk);
    check(res_valid === 1'b0, "R9 idle", {63'd0, res_valid}, 64'd0);
    // R10: stall
    res_ready = 1'b0;
    req_valid = 1'b1; req_a = pats[0]; req_b = pats[1]; req_op = 2'b00;
    @(negedge clk);
    req_a = pats[1]; req_b = pats[0]; req_op = 2'b10;
    for (int k = 0; k < 4; k++) begin
      check(req_ready === 1'b0, "R10 ready low", {63'd0, req_ready}, 64'd0);
      check(res_data === model(pats[0], pats[1], 2'b00), "R10 hold", res_data,
            model(pats[0], pats[1], 2'b00));
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(res_valid === 1'b1, "R10 second valid", {63'd0, res_valid}, 64'd1);
    check(res_data === model(pats[1], pats[0], 2'b10), "R10 second data", res_data,
          model(pats[1], pats[0], 2'b10));
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule